// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits between the decode/operand-read stage and the ALU of a five-stage in-order pipeline. It compares the source fields of the instruction now in the ALU stage (stage 3) against the destination fields of the instructions in the memory stage (stage 4) and the writeback stage (stage 5). When a dependence is found, it steers the affected ALU operand latch (X or Y) to take the result register of the later stage instead of the stale value read from the register file.

The unit is purely combinational. Forwarding is limited to pairs where both the producer and the consumer are ALU-class instructions. The second operand is forwarded only when the consumer takes that operand from a register and not from an immediate. Each operand also drives a 2-bit select, so the chosen source can be seen directly. Load-use stalls and branch handling are handled elsewhere in the pipeline.

Top module: `op_fwd_unit`

## Requirements
- R1: When no forwarding condition holds for an operand, that operand's select is 2'b00 and its output equals the register-file value (`rf_x` for X, `rf_y` for Y).
- R2: When stage 4 is valid and ALU-class (class code 3'd0), stage 3 is valid and ALU-class, and `s4_ra` equals `s3_rb`, then `x_sel` is 2'b01 and `x_out` equals `s4_z`.
- R3: When the stage-4 condition of R2 does not hold for X, but stage 5 is valid and ALU-class, stage 3 is valid and ALU-class, and `s5_ra` equals `s3_rb`, then `x_sel` is 2'b10 and `x_out` equals `s5_z`.
- R4: When stage 4 and stage 5 both qualify for the same operand, the stage-4 result is selected (select 2'b01), because it is the more recent write.
- R5: Operand Y follows the rules of R2 to R4, with the register comparison made against `s3_rc` and only while `s3_imm` is 0.
- R6: While `s3_imm` is 1, `y_sel` is 2'b00 and `y_out` equals `rf_y`, whatever the register fields hold. Forwarding of X is not affected.
- R7: A producer or consumer whose class code is anything other than 3'd0 (ALU) never causes a forward.
- R8: A stage whose valid bit is 0 (a bubble), whether it is a producer or the consumer, never causes a forward.
- R9: A select is never 2'b11, and each output always equals the source named by its select: 00 for the register file, 01 for stage-4 Z, 10 for stage-5 Z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s3_valid | input | 1 | ALU-stage instruction is valid |
| s3_cls | input | 3 | ALU-stage class code (3'd0 = ALU) |
| s3_rb | input | 5 | ALU-stage first source register |
| s3_rc | input | 5 | ALU-stage second source register |
| s3_imm | input | 1 | ALU-stage instruction takes an immediate in place of rc |
| s4_valid | input | 1 | Memory-stage instruction is valid |
| s4_cls | input | 3 | Memory-stage class code |
| s4_ra | input | 5 | Memory-stage destination register |
| s4_z | input | 32 | Memory-stage result register |
| s5_valid | input | 1 | Writeback-stage instruction is valid |
| s5_cls | input | 3 | Writeback-stage class code |
| s5_ra | input | 5 | Writeback-stage destination register |
| s5_z | input | 32 | Writeback-stage result register |
| rf_x | input | 32 | Register-file value read for operand X |
| rf_y | input | 32 | Register-file value read for operand Y |
| x_out | output | 32 | Selected value for operand latch X |
| y_out | output | 32 | Selected value for operand latch Y |
| x_sel | output | 2 | Source select for X |
| y_sel | output | 2 | Source select for Y |

## Verification
Every output of this unit is due in the same cycle as its inputs, with no register on the path. The bench therefore changes all inputs on the falling clock edge and samples the selects and operand values a quarter period later, well before the next rising edge. Random vectors draw register numbers from a small range, so matches and double matches happen often. Directed vectors cover the priority, immediate, bubble and class corner cases. Expected selects and values come from a bench function built on the requirements.

// File: rtl/op_fwd_pkg.sv
package op_fwd_pkg;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_ALU    = 3'd0,
      CLS_LOAD   = 3'd1,
      CLS_LADR   = 3'd2,
      CLS_STORE  = 3'd3,
      CLS_BRANCH = 3'd4,
      CLS_OTHER  = 3'd5
   } instr_cls_e;

   typedef enum logic [1:0] {
      SEL_RF = 2'b00,
      SEL_S4 = 2'b01,
      SEL_S5 = 2'b10
   } op_sel_e;
endpackage

// File: rtl/op_fwd_match.sv
module op_fwd_match #(
   parameter int REG_W = 5
) (
   input  logic                        prod_valid,
   input  logic [op_fwd_pkg::CLS_W-1:0] prod_cls,
   input  logic [REG_W-1:0]             prod_ra,
   input  logic                        cons_valid,
   input  logic [op_fwd_pkg::CLS_W-1:0] cons_cls,
   input  logic [REG_W-1:0]             cons_src,
   input  logic                        cons_uses_reg,
   output logic                        hit
);
   import op_fwd_pkg::*;

   logic both_alu;
   logic both_live;

   always_comb begin
      both_alu  = (prod_cls == CLS_ALU) && (cons_cls == CLS_ALU);
      both_live = prod_valid && cons_valid;
      hit       = both_alu && both_live && cons_uses_reg && (prod_ra == cons_src);
   end
endmodule

// File: rtl/op_fwd_operand_sel.sv
module op_fwd_operand_sel #(
   parameter int DATA_W = 32
) (
   input  logic              hit_s4,
   input  logic              hit_s5,
   input  logic [DATA_W-1:0] z_s4,
   input  logic [DATA_W-1:0] z_s5,
   input  logic [DATA_W-1:0] rf_val,
   output logic [1:0]        sel,
   output logic [DATA_W-1:0] val
);
   import op_fwd_pkg::*;

   always_comb begin
      if (hit_s4) begin
         sel = SEL_S4;
         val = z_s4;
      end else if (hit_s5) begin
         sel = SEL_S5;
         val = z_s5;
      end else begin
         sel = SEL_RF;
         val = rf_val;
      end
   end
endmodule

// File: rtl/op_fwd_unit.sv
module op_fwd_unit #(
   parameter int REG_W  = 5,
   parameter int DATA_W = 32
) (
   input  logic                        s3_valid,
   input  logic [op_fwd_pkg::CLS_W-1:0] s3_cls,
   input  logic [REG_W-1:0]             s3_rb,
   input  logic [REG_W-1:0]             s3_rc,
   input  logic                        s3_imm,
   input  logic                        s4_valid,
   input  logic [op_fwd_pkg::CLS_W-1:0] s4_cls,
   input  logic [REG_W-1:0]             s4_ra,
   input  logic [DATA_W-1:0]            s4_z,
   input  logic                        s5_valid,
   input  logic [op_fwd_pkg::CLS_W-1:0] s5_cls,
   input  logic [REG_W-1:0]             s5_ra,
   input  logic [DATA_W-1:0]            s5_z,
   input  logic [DATA_W-1:0]            rf_x,
   input  logic [DATA_W-1:0]            rf_y,
   output logic [DATA_W-1:0]            x_out,
   output logic [DATA_W-1:0]            y_out,
   output logic [1:0]                   x_sel,
   output logic [1:0]                   y_sel
);
   localparam int NUM_OPS = 2;
   localparam int OP_X    = 0;
   localparam int OP_Y    = 1;

   if (REG_W < 1) begin : g_bad_reg_w
      $error("op_fwd_unit: REG_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("op_fwd_unit: DATA_W must be at least 1");
   end

   logic [REG_W-1:0]  op_src   [NUM_OPS];
   logic              op_reg   [NUM_OPS];
   logic [DATA_W-1:0] op_rf    [NUM_OPS];
   logic [DATA_W-1:0] op_val   [NUM_OPS];
   logic [1:0]        op_sel   [NUM_OPS];

   always_comb begin
      op_src[OP_X] = s3_rb;
      op_src[OP_Y] = s3_rc;
      op_reg[OP_X] = 1'b1;
      op_reg[OP_Y] = !s3_imm;
      op_rf[OP_X]  = rf_x;
      op_rf[OP_Y]  = rf_y;
   end

   for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
      logic hit_s4;
      logic hit_s5;

      op_fwd_match #(.REG_W(REG_W)) u_match_s4 (
         .prod_valid    (s4_valid),
         .prod_cls      (s4_cls),
         .prod_ra       (s4_ra),
         .cons_valid    (s3_valid),
         .cons_cls      (s3_cls),
         .cons_src      (op_src[g]),
         .cons_uses_reg (op_reg[g]),
         .hit           (hit_s4)
      );

      op_fwd_match #(.REG_W(REG_W)) u_match_s5 (
         .prod_valid    (s5_valid),
         .prod_cls      (s5_cls),
         .prod_ra       (s5_ra),
         .cons_valid    (s3_valid),
         .cons_cls      (s3_cls),
         .cons_src      (op_src[g]),
         .cons_uses_reg (op_reg[g]),
         .hit           (hit_s5)
      );

      op_fwd_operand_sel #(.DATA_W(DATA_W)) u_sel (
         .hit_s4 (hit_s4),
         .hit_s5 (hit_s5),
         .z_s4   (s4_z),
         .z_s5   (s5_z),
         .rf_val (op_rf[g]),
         .sel    (op_sel[g]),
         .val    (op_val[g])
      );
   end

   assign x_out = op_val[OP_X];
   assign y_out = op_val[OP_Y];
   assign x_sel = op_sel[OP_X];
   assign y_sel = op_sel[OP_Y];
endmodule

// File: rtl/op_fwd_unit_chk.sv
module op_fwd_unit_chk #(
   parameter int REG_W  = 5,
   parameter int DATA_W = 32
) (
   input logic                        s3_valid,
   input logic [op_fwd_pkg::CLS_W-1:0] s3_cls,
   input logic [REG_W-1:0]             s3_rb,
   input logic [REG_W-1:0]             s3_rc,
   input logic                        s3_imm,
   input logic                        s4_valid,
   input logic [op_fwd_pkg::CLS_W-1:0] s4_cls,
   input logic [REG_W-1:0]             s4_ra,
   input logic [DATA_W-1:0]            s4_z,
   input logic                        s5_valid,
   input logic [op_fwd_pkg::CLS_W-1:0] s5_cls,
   input logic [REG_W-1:0]             s5_ra,
   input logic [DATA_W-1:0]            s5_z,
   input logic [DATA_W-1:0]            rf_x,
   input logic [DATA_W-1:0]            rf_y,
   input logic [DATA_W-1:0]            x_out,
   input logic [DATA_W-1:0]            y_out,
   input logic [1:0]                   x_sel,
   input logic [1:0]                   y_sel
);
   import op_fwd_pkg::*;

   logic s4_ok;
   logic s5_ok;
   logic s3_ok;

   always_comb begin
      s3_ok = s3_valid && (s3_cls == CLS_ALU);
      s4_ok = s4_valid && (s4_cls == CLS_ALU);
      s5_ok = s5_valid && (s5_cls == CLS_ALU);

      // R9: selects stay within the three legal codes
      a_r9_sel_legal: assert (x_sel != 2'b11 && y_sel != 2'b11)
         else $error("select 2'b11 seen");

      // R9: X output agrees with the source its select names
      a_r9_x_follows_sel: assert ((x_sel == SEL_RF && x_out == rf_x) ||
                                  (x_sel == SEL_S4 && x_out == s4_z) ||
                                  (x_sel == SEL_S5 && x_out == s5_z))
         else $error("x_out does not match x_sel");

      // R9: Y output agrees with the source its select names
      a_r9_y_follows_sel: assert ((y_sel == SEL_RF && y_out == rf_y) ||
                                  (y_sel == SEL_S4 && y_out == s4_z) ||
                                  (y_sel == SEL_S5 && y_out == s5_z))
         else $error("y_out does not match y_sel");

      // R6: immediate form keeps Y on the register file
      a_r6_imm_blocks_y: assert (!s3_imm || y_sel == SEL_RF)
         else $error("Y forwarded under immediate");

      // R7, R8: no forward without a live ALU consumer
      a_r8_consumer_gate: assert (s3_ok || (x_sel == SEL_RF && y_sel == SEL_RF))
         else $error("forward with bubble or non-ALU consumer");

      // R7, R8: stage-4 select needs a live ALU producer in stage 4
      a_r8_s4_gate: assert (s4_ok || (x_sel != SEL_S4 && y_sel != SEL_S4))
         else $error("stage-4 forward without live ALU producer");

      // R7, R8: stage-5 select needs a live ALU producer in stage 5
      a_r8_s5_gate: assert (s5_ok || (x_sel != SEL_S5 && y_sel != SEL_S5))
         else $error("stage-5 forward without live ALU producer");

      // R4: when stage 4 qualifies for X, it wins over stage 5
      a_r4_newest_wins: assert (!(s3_ok && s4_ok && s4_ra == s3_rb) || x_sel == SEL_S4)
         else $error("stage-4 match for X not selected");

      // R2, R3: a selected stage must actually match the source field
      a_r3_x_match_real: assert ((x_sel != SEL_S4 || s4_ra == s3_rb) &&
                                 (x_sel != SEL_S5 || s5_ra == s3_rb))
         else $error("X forwarded without register match");
   end
endmodule

bind op_fwd_unit op_fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/op_fwd_unit_tb_top.sv
module op_fwd_unit_tb_top;
   import op_fwd_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int REG_W      = 5;
   localparam int DATA_W     = 32;
   localparam int N_RANDOM   = 2000;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic              s3_valid, s3_imm, s4_valid, s5_valid;
   logic [2:0]        s3_cls, s4_cls, s5_cls;
   logic [REG_W-1:0]  s3_rb, s3_rc, s4_ra, s5_ra;
   logic [DATA_W-1:0] s4_z, s5_z, rf_x, rf_y, x_out, y_out;
   logic [1:0]        x_sel, y_sel;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   op_fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) dut_i (
      .s3_valid(s3_valid), .s3_cls(s3_cls), .s3_rb(s3_rb), .s3_rc(s3_rc), .s3_imm(s3_imm),
      .s4_valid(s4_valid), .s4_cls(s4_cls), .s4_ra(s4_ra), .s4_z(s4_z),
      .s5_valid(s5_valid), .s5_cls(s5_cls), .s5_ra(s5_ra), .s5_z(s5_z),
      .rf_x(rf_x), .rf_y(rf_y),
      .x_out(x_out), .y_out(y_out), .x_sel(x_sel), .y_sel(y_sel)
   );

   // Expected select per requirements: 0 = register file, 1 = stage 4, 2 = stage 5
   function automatic logic [1:0] exp_sel(input logic [REG_W-1:0] src, input logic uses_reg);
      logic c_ok, p4, p5;
      c_ok = s3_valid && (s3_cls == 3'd0) && uses_reg;
      p4   = c_ok && s4_valid && (s4_cls == 3'd0) && (s4_ra == src);
      p5   = c_ok && s5_valid && (s5_cls == 3'd0) && (s5_ra == src);
      if (p4)      return 2'b01;
      else if (p5) return 2'b10;
      else         return 2'b00;
   endfunction

   function automatic logic [DATA_W-1:0] exp_val(input logic [1:0] s, input logic [DATA_W-1:0] rf);
      case (s)
         2'b01:   return s4_z;
         2'b10:   return s5_z;
         default: return rf;
      endcase
   endfunction

   function automatic string req_tag(input logic [1:0] s, input bit is_y);
      if (is_y && s3_imm)                            return "R6";
      if (!s3_valid || (s4_cls != 3'd0 && s5_cls != 3'd0 && s3_cls == 3'd0) && !s4_valid) return "R8";
      if (s3_cls != 3'd0)                            return "R7";
      if (s == 2'b01 && s5_valid && s5_cls == 3'd0 &&
          s5_ra == (is_y ? s3_rc : s3_rb))            return "R4";
      if (is_y && s != 2'b00)                        return "R5";
      if (s == 2'b01)                                return "R2";
      if (s == 2'b10)                                return "R3";
      return "R1";
   endfunction

   task automatic check_field(input string req, input string name,
                              input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, name, act, exp);
      end
   endtask

   task automatic check_now(input string force_tag);
      logic [1:0] ex, ey;
      string tx, ty;
      ex = exp_sel(s3_rb, 1'b1);
      ey = exp_sel(s3_rc, !s3_imm);
      tx = (force_tag != "") ? force_tag : req_tag(ex, 1'b0);
      ty = (force_tag != "") ? force_tag : req_tag(ey, 1'b1);
      check_field(tx, "x_sel", {30'd0, x_sel}, {30'd0, ex});
      check_field(tx, "x_out", x_out, exp_val(ex, rf_x));
      check_field(ty, "y_sel", {30'd0, y_sel}, {30'd0, ey});
      check_field(ty, "y_out", y_out, exp_val(ey, rf_y));
      // R9: selects never take the unused code
      check_field("R9", "sel_code", {30'd0, (x_sel == 2'b11) || (y_sel == 2'b11)}, 32'd0);
   endtask

   // Drive on the falling edge, sample a quarter period later
   task automatic apply(input logic v3, input logic [2:0] c3, input logic [4:0] rb, input logic [4:0] rc,
                        input logic imm, input logic v4, input logic [2:0] c4, input logic [4:0] ra4,
                        input logic v5, input logic [2:0] c5, input logic [4:0] ra5,
                        input string tag);
      @(negedge clk);
      s3_valid = v3; s3_cls = c3; s3_rb = rb; s3_rc = rc; s3_imm = imm;
      s4_valid = v4; s4_cls = c4; s4_ra = ra4;
      s5_valid = v5; s5_cls = c5; s5_ra = ra5;
      s4_z = $urandom; s5_z = $urandom; rf_x = $urandom; rf_y = $urandom;
      #(CLK_PERIOD/4);
      check_now(tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      s3_valid = 0; s3_cls = 3'd5; s3_rb = 0; s3_rc = 0; s3_imm = 0;
      s4_valid = 0; s4_cls = 3'd5; s4_ra = 0; s4_z = 32'h1111_1111;
      s5_valid = 0; s5_cls = 3'd5; s5_ra = 0; s5_z = 32'h2222_2222;
      rf_x = 32'hAAAA_0001; rf_y = 32'hBBBB_0002;
      #(CLK_PERIOD/4);
      // R1: idle state passes register-file operands
      check_now("R1");

      // R1: all valid ALU, no register overlap
      apply(1, 3'd0, 5'd3, 5'd4, 0, 1, 3'd0, 5'd7, 1, 3'd0, 5'd9, "R1");
      // R2: stage 4 feeds X
      apply(1, 3'd0, 5'd6, 5'd4, 0, 1, 3'd0, 5'd6, 1, 3'd0, 5'd9, "R2");
      // R3: stage 5 feeds X
      apply(1, 3'd0, 5'd6, 5'd4, 0, 1, 3'd0, 5'd1, 1, 3'd0, 5'd6, "R3");
      // R4: both match X and Y, stage 4 wins
      apply(1, 3'd0, 5'd8, 5'd8, 0, 1, 3'd0, 5'd8, 1, 3'd0, 5'd8, "R4");
      // R5: stage 5 feeds Y, stage 4 feeds X
      apply(1, 3'd0, 5'd2, 5'd12, 0, 1, 3'd0, 5'd2, 1, 3'd0, 5'd12, "R5");
      // R6: immediate blocks Y while X still forwards
      apply(1, 3'd0, 5'd10, 5'd10, 1, 1, 3'd0, 5'd10, 1, 3'd0, 5'd10, "R6");
      // R7: load producer in stage 4 does not forward; stage 5 ALU does
      apply(1, 3'd0, 5'd5, 5'd5, 0, 1, 3'd1, 5'd5, 1, 3'd0, 5'd5, "R7");
      // R7: non-ALU consumer never forwarded
      apply(1, 3'd3, 5'd5, 5'd5, 0, 1, 3'd0, 5'd5, 1, 3'd0, 5'd5, "R7");
      // R8: bubble in stage 4 skipped, stage 5 used
      apply(1, 3'd0, 5'd11, 5'd11, 0, 0, 3'd0, 5'd11, 1, 3'd0, 5'd11, "R8");
      // R8: bubble in stage 3 blocks all forwarding
      apply(0, 3'd0, 5'd11, 5'd11, 0, 1, 3'd0, 5'd11, 1, 3'd0, 5'd11, "R8");
      // R8: bubbles in both producers
      apply(1, 3'd0, 5'd0, 5'd0, 0, 0, 3'd0, 5'd0, 0, 3'd0, 5'd0, "R8");

      // Random vectors with small register range to make matches frequent
      for (int i = 0; i < N_RANDOM; i++) begin
         apply($urandom_range(0, 7) != 0,
               ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 5)) : 3'd0,
               5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
               $urandom_range(0, 3) == 0,
               $urandom_range(0, 7) != 0,
               ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 5)) : 3'd0,
               5'($urandom_range(0, 3)),
               $urandom_range(0, 7) != 0,
               ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 5)) : 3'd0,
               5'($urandom_range(0, 3)),
               "");
      end
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule